// File: doc/BRIEF.md
# Frame Buffer Pixel Unpacker with Color Palette

This block takes 32-bit words read from a frame buffer and turns them into a stream of 32-bit pixels laid out as alpha, red, green, blue from the top byte down. Each word comes with a format code. The block handles 16-bit, 24-bit and 32-bit direct-color layouts. Components narrower than 8 bits are widened by copying their top bits into the new low bits. Layouts that carry no alpha, or whose alpha is marked as unused, come out fully opaque.

Indexed formats use 1, 2, 4 or 8 bits per pixel. Each index is looked up in an internal palette of 256 colors, each 24 bits wide, and indexed pixels are opaque. Software loads the palette and reads it back through its own address/data port. That port runs beside the pixel stream and does not corrupt lookups that are already under way.

A two-state controller drives the pixel stream. In `S_IDLE`, `in_ready` is high and an accepted word moves the block to `S_EMIT`. In `S_EMIT`, one pixel slot is produced each cycle. The transitions are:
- `S_EMIT` stays in `S_EMIT` while pixels of the current word remain.
- On the last slot, `S_EMIT` stays in `S_EMIT` if a new word is accepted in that same cycle.
- On the last slot, `S_EMIT` returns to `S_IDLE` if no new word arrives.

Every pixel appears on `out_valid`/`out_pixel` one register stage after its slot. This delay is the same for direct and indexed formats.

Top module: `pix_unpack_top`

## Requirements
- R1: Format codes are: 0 ARGB4444, 1 RGBA4444, 2 RGB565, 3 ARGB1555, 4 ARGB8888, 5 RGBA8888, 6 xRGB8888, 7 RGBx8888, 8 RGB888 packed, 9/10/11/12 indexed at 1/2/4/8 bits, 13 xRGB4444, 14 xRGB1555, 15 reserved. A 16-bit format yields two pixels per word, bits [15:0] first, then bits [31:16].
- R2: A 4-bit component v becomes the byte {v,v}. In ARGB4444 the halfword fields are A[15:12] R[11:8] G[7:4] B[3:0]. In RGBA4444 they are R[15:12] G[11:8] B[7:4] A[3:0].
- R3: In RGB565 (R[15:11] G[10:5] B[4:0]) and ARGB1555 (A[15] R[14:10] G[9:5] B[4:0]), a 5-bit value v becomes {v,v[4:2]} and a 6-bit value becomes {v,v[5:4]`. A 1-bit alpha becomes 0x00 or 0xFF.
- R4: Alpha is forced to 0xFF for xRGB8888, RGBx8888, xRGB4444, xRGB1555, RGB565, RGB888 and all indexed formats, whatever the unused field holds.
- R5: ARGB8888 passes the word through unchanged. RGBA8888 maps R[31:24] G[23:16] B[15:8] A[7:0]. xRGB8888 takes colour from [23:0]. RGBx8888 takes colour from [31:8].
- R6: RGB888 treats consecutive words as a little-endian byte stream. Each group of three bytes b0,b1,b2 gives pixel {0xFF,b2,b1,b0}, so three words give four pixels. Any word of another format restarts the byte alignment.
- R7: `in_ready` is high only in `S_IDLE` or on the last slot of the current word. Once the first pixel of a word appears, its remaining pixels follow on consecutive cycles.
- R8: Indexed pixels are taken from the most significant end of the word first, so one word yields 32, 16, 8 or 4 pixels. Each index selects a palette entry, and the output is {0xFF, entry}.
- R9: A palette write (`pal_we`) updates the entry at `pal_addr`. A read (`pal_re`) returns that entry on `pal_rdata`, with `pal_rvalid` high, one cycle later.
- R10: When a palette write hits the entry that a lookup reads in the same cycle, the lookup returns the old color. Later lookups return the new color.
- R11: A word with the reserved code is consumed and produces no pixel.
- R12: After reset, `out_valid` and `pal_rvalid` are low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input word offered |
| in_ready | output | 1 | Block accepts the offered word this cycle |
| in_fmt | input | 4 | Format code of the offered word |
| in_data | input | 32 | Frame buffer word |
| pal_we | input | 1 | Palette write strobe |
| pal_re | input | 1 | Palette read strobe |
| pal_addr | input | 8 | Palette entry address |
| pal_wdata | input | 24 | Color to write, {R,G,B} |
| pal_rdata | output | 24 | Color read back |
| pal_rvalid | output | 1 | pal_rdata holds the result of the read one cycle earlier |
| out_valid | output | 1 | Output pixel valid |
| out_pixel | output | 32 | Pixel {A,R,G,B} |

## Verification
Two functions can fall in the same cycle: a software write to the palette and a pixel lookup that reads the same entry. The bench sends an 8-bit indexed word whose four indices are all the same entry. It times a write to that entry so that it lands on the clock edge where the second pixel's lookup is captured. The scoreboard then expects the old color on the first two pixels and the new color on the last two. A readback afterwards confirms that the write itself took effect.

// File: rtl/pu_pkg.sv
package pu_pkg;

    localparam int WORD_W = 32;
    localparam int PIX_W  = 32;

    typedef enum logic [3:0] {
        F_ARGB4444 = 4'd0,
        F_RGBA4444 = 4'd1,
        F_RGB565   = 4'd2,
        F_ARGB1555 = 4'd3,
        F_ARGB8888 = 4'd4,
        F_RGBA8888 = 4'd5,
        F_XRGB8888 = 4'd6,
        F_RGBX8888 = 4'd7,
        F_RGB888   = 4'd8,
        F_IDX1     = 4'd9,
        F_IDX2     = 4'd10,
        F_IDX4     = 4'd11,
        F_IDX8     = 4'd12,
        F_XRGB4444 = 4'd13,
        F_XRGB1555 = 4'd14,
        F_RSVD     = 4'd15
    } fmt_e;

    typedef enum logic {
        S_IDLE = 1'b0,
        S_EMIT = 1'b1
    } st_e;

    // Widening by copying the most significant bits into the low bits
    function automatic logic [7:0] widen4(input logic [3:0] v);
        return {v, v};
    endfunction

    function automatic logic [7:0] widen5(input logic [4:0] v);
        return {v, v[4:2]};
    endfunction

    function automatic logic [7:0] widen6(input logic [5:0] v);
        return {v, v[5:4]};
    endfunction

endpackage

// File: rtl/pu_conv.sv
// Combinational format decode: pixel count per word and the pixel in slot k
module pu_conv
    import pu_pkg::*;
#(
    parameter int CNT_W = 6
) (
    input  fmt_e               fmt,
    input  logic [WORD_W-1:0]  word,
    input  logic [CNT_W-1:0]   k,
    input  logic [1:0]         ph24,
    input  logic [15:0]        res,
    output logic [CNT_W-1:0]   npix,
    output logic [PIX_W-1:0]   pix,
    output logic               is_idx,
    output logic [7:0]         idx
);

    logic [15:0]       h;
    logic [3:0]        bpp;
    logic [7:0]        amt;
    logic [WORD_W-1:0] sh;

    assign h = k[0] ? word[31:16] : word[15:0];

    always_comb begin
        npix   = '0;
        pix    = '0;
        is_idx = 1'b0;
        bpp    = 4'd0;
        unique case (fmt)
            F_ARGB4444: begin
                npix = CNT_W'(2);
                pix  = {widen4(h[15:12]), widen4(h[11:8]), widen4(h[7:4]), widen4(h[3:0])};
            end
            F_XRGB4444: begin
                npix = CNT_W'(2);
                pix  = {8'hFF, widen4(h[11:8]), widen4(h[7:4]), widen4(h[3:0])};
            end
            F_RGBA4444: begin
                npix = CNT_W'(2);
                pix  = {widen4(h[3:0]), widen4(h[15:12]), widen4(h[11:8]), widen4(h[7:4])};
            end
            F_RGB565: begin
                npix = CNT_W'(2);
                pix  = {8'hFF, widen5(h[15:11]), widen6(h[10:5]), widen5(h[4:0])};
            end
            F_ARGB1555: begin
                npix = CNT_W'(2);
                pix  = {{8{h[15]}}, widen5(h[14:10]), widen5(h[9:5]), widen5(h[4:0])};
            end
            F_XRGB1555: begin
                npix = CNT_W'(2);
                pix  = {8'hFF, widen5(h[14:10]), widen5(h[9:5]), widen5(h[4:0])};
            end
            F_ARGB8888: begin
                npix = CNT_W'(1);
                pix  = word;
            end
            F_XRGB8888: begin
                npix = CNT_W'(1);
                pix  = {8'hFF, word[23:0]};
            end
            F_RGBA8888: begin
                npix = CNT_W'(1);
                pix  = {word[7:0], word[31:8]};
            end
            F_RGBX8888: begin
                npix = CNT_W'(1);
                pix  = {8'hFF, word[31:8]};
            end
            F_RGB888: begin
                if (ph24 == 2'd2) begin
                    npix = CNT_W'(2);
                    pix  = k[0] ? {8'hFF, word[31:8]} : {8'hFF, word[7:0], res};
                end else if (ph24 == 2'd1) begin
                    npix = CNT_W'(1);
                    pix  = {8'hFF, word[15:0], res[7:0]};
                end else begin
                    npix = CNT_W'(1);
                    pix  = {8'hFF, word[23:0]};
                end
            end
            F_IDX1: begin
                npix = CNT_W'(32); is_idx = 1'b1; bpp = 4'd1;
            end
            F_IDX2: begin
                npix = CNT_W'(16); is_idx = 1'b1; bpp = 4'd2;
            end
            F_IDX4: begin
                npix = CNT_W'(8);  is_idx = 1'b1; bpp = 4'd4;
            end
            F_IDX8: begin
                npix = CNT_W'(4);  is_idx = 1'b1; bpp = 4'd8;
            end
            F_RSVD: begin
                npix = '0;
            end
        endcase
        amt = 8'(k) * {4'd0, bpp};
        sh  = word << amt;
        idx = sh[31:24] >> (4'd8 - bpp);
    end

endmodule

// File: rtl/pu_ctrl.sv
// Word acceptance, slot sequencing and RGB888 byte alignment
module pu_ctrl
    import pu_pkg::*;
#(
    parameter int CNT_W = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic [WORD_W-1:0]  in_data,
    input  fmt_e               in_fmt,
    input  logic [CNT_W-1:0]   npix,
    output logic               in_ready,
    output logic               emit,
    output logic               busy,
    output logic               last,
    output logic [WORD_W-1:0]  cur_word,
    output fmt_e               cur_fmt,
    output logic [CNT_W-1:0]   k,
    output logic [1:0]         ph24,
    output logic [15:0]        res
);

    st_e  st, st_nx;
    logic accept;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) st <= S_IDLE;
        else        st <= st_nx;
    end

    // Next state
    always_comb begin
        st_nx = st;
        unique case (st)
            S_IDLE: st_nx = in_valid ? S_EMIT : S_IDLE;
            S_EMIT: st_nx = (last && !in_valid) ? S_IDLE : S_EMIT;
        endcase
    end

    // Outputs
    always_comb begin
        busy     = (st == S_EMIT);
        last     = busy && ((npix == '0) || (k == npix - 1'b1));
        emit     = busy && (npix != '0);
        in_ready = !busy || last;
        accept   = in_valid && in_ready;
    end

    always_ff @(posedge clk) begin
        if (accept) begin
            cur_word <= in_data;
            cur_fmt  <= in_fmt;
            k        <= '0;
        end else if (busy) begin
            k <= k + 1'b1;
        end
    end

    // Byte alignment across RGB888 words
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph24 <= 2'd0;
            res  <= '0;
        end else if (last) begin
            if (cur_fmt != F_RGB888) begin
                ph24 <= 2'd0;
            end else if (ph24 == 2'd0) begin
                ph24     <= 2'd1;
                res[7:0] <= cur_word[31:24];
            end else if (ph24 == 2'd1) begin
                ph24 <= 2'd2;
                res  <= cur_word[31:16];
            end else begin
                ph24 <= 2'd0;
            end
        end
    end

endmodule

// File: rtl/pu_palette.sv
// Color table: lookup read port plus a software write/read port
module pu_palette #(
    parameter int AW = 8,
    parameter int CW = 24
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          lk_en,
    input  logic [AW-1:0] lk_addr,
    output logic [CW-1:0] lk_color,
    input  logic          sw_we,
    input  logic          sw_re,
    input  logic [AW-1:0] sw_addr,
    input  logic [CW-1:0] sw_wdata,
    output logic [CW-1:0] sw_rdata,
    output logic          sw_rvalid
);

    localparam int DEPTH = 1 << AW;

    logic [CW-1:0] mem [DEPTH];

    // Reads see the contents from before a write on the same edge
    always_ff @(posedge clk) begin
        if (lk_en) lk_color <= mem[lk_addr];
        if (sw_re) sw_rdata <= mem[sw_addr];
        if (sw_we) mem[sw_addr] <= sw_wdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) sw_rvalid <= 1'b0;
        else        sw_rvalid <= sw_re;
    end

endmodule

// File: rtl/pix_unpack_top.sv
module pix_unpack_top
    import pu_pkg::*;
#(
    parameter int PAL_AW = 8,
    parameter int COL_W  = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [3:0]        in_fmt,
    input  logic [31:0]       in_data,
    input  logic              pal_we,
    input  logic              pal_re,
    input  logic [PAL_AW-1:0] pal_addr,
    input  logic [COL_W-1:0]  pal_wdata,
    output logic [COL_W-1:0]  pal_rdata,
    output logic              pal_rvalid,
    output logic              out_valid,
    output logic [31:0]       out_pixel
);

    localparam int CNT_W = $clog2(WORD_W) + 1;

    logic [CNT_W-1:0]  npix, k;
    logic              emit, busy, last, is_idx;
    logic [WORD_W-1:0] cur_word;
    fmt_e              cur_fmt;
    logic [1:0]        ph24;
    logic [15:0]       res;
    logic [PIX_W-1:0]  pix;
    logic [7:0]        idx;
    logic [COL_W-1:0]  lk_color;

    logic              s1_valid, s1_idx;
    logic [PIX_W-1:0]  s1_pix;

    pu_ctrl #(.CNT_W(CNT_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_data(in_data), .in_fmt(fmt_e'(in_fmt)),
        .npix(npix), .in_ready(in_ready), .emit(emit), .busy(busy), .last(last),
        .cur_word(cur_word), .cur_fmt(cur_fmt), .k(k), .ph24(ph24), .res(res)
    );

    pu_conv #(.CNT_W(CNT_W)) u_conv (
        .fmt(cur_fmt), .word(cur_word), .k(k), .ph24(ph24), .res(res),
        .npix(npix), .pix(pix), .is_idx(is_idx), .idx(idx)
    );

    pu_palette #(.AW(PAL_AW), .CW(COL_W)) u_pal (
        .clk(clk), .rst_n(rst_n),
        .lk_en(emit && is_idx), .lk_addr(PAL_AW'(idx)), .lk_color(lk_color),
        .sw_we(pal_we), .sw_re(pal_re), .sw_addr(pal_addr),
        .sw_wdata(pal_wdata), .sw_rdata(pal_rdata), .sw_rvalid(pal_rvalid)
    );

    // Output stage aligns direct pixels with the palette read latency
    always_ff @(posedge clk) begin
        if (!rst_n) s1_valid <= 1'b0;
        else        s1_valid <= emit;
    end

    always_ff @(posedge clk) begin
        s1_idx <= is_idx;
        s1_pix <= pix;
    end

    assign out_valid = s1_valid;
    assign out_pixel = s1_idx ? {{(PIX_W-COL_W){1'b1}}, lk_color} : s1_pix;

endmodule

// File: rtl/pu_check.sv
module pu_check
    import pu_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        in_ready,
    input logic        busy,
    input logic        last,
    input logic        out_valid,
    input logic [31:0] out_pixel,
    input logic        pal_re,
    input logic        pal_rvalid,
    input logic [3:0]  cur_fmt
);

    p_expand_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(cur_fmt) == F_ARGB4444) |->
        (out_pixel[31:28] == out_pixel[27:24] && out_pixel[23:20] == out_pixel[19:16] &&
         out_pixel[15:12] == out_pixel[11:8]  && out_pixel[7:4]   == out_pixel[3:0]));

    p_onebit_alpha_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(cur_fmt) == F_ARGB1555) |->
        (out_pixel[31:24] == 8'h00 || out_pixel[31:24] == 8'hFF));

    p_opaque_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && ($past(cur_fmt) inside {F_XRGB8888, F_RGBX8888, F_XRGB4444, F_XRGB1555,
                                              F_RGB565, F_RGB888, F_IDX1, F_IDX2, F_IDX4, F_IDX8}))
        |-> out_pixel[31:24] == 8'hFF);

    p_hold_ready_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !last) |-> !in_ready);

    p_idle_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |=> !out_valid);

    p_read_answer_r9: assert property (@(posedge clk) disable iff (!rst_n)
        pal_re |=> pal_rvalid);

    p_read_none_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !pal_re |=> !pal_rvalid);

endmodule

bind pix_unpack_top pu_check u_chk (
    .clk(clk), .rst_n(rst_n), .in_ready(in_ready), .busy(busy), .last(last),
    .out_valid(out_valid), .out_pixel(out_pixel), .pal_re(pal_re),
    .pal_rvalid(pal_rvalid), .cur_fmt(cur_fmt)
);

// File: tb/pix_unpack_top_test.sv
module pix_unpack_top_test;
    import pu_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [3:0]  in_fmt = 4'd0;
    logic [31:0] in_data = '0;
    logic        pal_we = 1'b0, pal_re = 1'b0;
    logic [7:0]  pal_addr = '0;
    logic [23:0] pal_wdata = '0;
    logic [23:0] pal_rdata;
    logic        pal_rvalid;
    logic        out_valid;
    logic [31:0] out_pixel;

    int nchk = 0, nfail = 0;
    logic [31:0] exp_q[$];
    string       tag_q[$];
    logic [7:0]  bq[$];
    logic [23:0] pal_model [256];

    always #2 clk = ~clk;

    pix_unpack_top uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_fmt(in_fmt), .in_data(in_data), .pal_we(pal_we), .pal_re(pal_re),
        .pal_addr(pal_addr), .pal_wdata(pal_wdata), .pal_rdata(pal_rdata),
        .pal_rvalid(pal_rvalid), .out_valid(out_valid), .out_pixel(out_pixel)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%08h expected=%08h", tag, act, expv);
        end
    endtask

    function automatic logic [7:0] e4(input logic [3:0] v);
        return 8'(v) * 8'd17;
    endfunction
    function automatic logic [7:0] e5(input logic [4:0] v);
        return (8'(v) << 3) | (8'(v) >> 2);
    endfunction
    function automatic logic [7:0] e6(input logic [5:0] v);
        return (8'(v) << 2) | (8'(v) >> 4);
    endfunction

    task automatic push(input logic [31:0] p, input string tag);
        exp_q.push_back(p);
        tag_q.push_back(tag);
    endtask

    task automatic drive_word(input logic [3:0] f, input logic [31:0] w);
        @(negedge clk);
        in_valid = 1'b1; in_fmt = f; in_data = w;
        while (!in_ready) @(negedge clk);
        @(posedge clk);
        #1 in_valid = 1'b0;
    endtask

    // Driver: computes the expected pixels from the requirements, then drives
    task automatic send(input logic [3:0] f, input logic [31:0] w, input string tag);
        if (f != F_RGB888) bq.delete();
        case (f)
            F_ARGB4444, F_RGBA4444, F_XRGB4444, F_RGB565, F_ARGB1555, F_XRGB1555: begin
                for (int i = 0; i < 2; i++) begin
                    logic [15:0] h;
                    h = w[16*i +: 16];
                    case (f)
                        F_ARGB4444: push({e4(h[15:12]), e4(h[11:8]), e4(h[7:4]), e4(h[3:0])}, tag);
                        F_XRGB4444: push({8'hFF, e4(h[11:8]), e4(h[7:4]), e4(h[3:0])}, tag);
                        F_RGBA4444: push({e4(h[3:0]), e4(h[15:12]), e4(h[11:8]), e4(h[7:4])}, tag);
                        F_RGB565:   push({8'hFF, e5(h[15:11]), e6(h[10:5]), e5(h[4:0])}, tag);
                        F_ARGB1555: push({h[15] ? 8'hFF : 8'h00, e5(h[14:10]), e5(h[9:5]), e5(h[4:0])}, tag);
                        default:    push({8'hFF, e5(h[14:10]), e5(h[9:5]), e5(h[4:0])}, tag);
                    endcase
                end
            end
            F_ARGB8888: push(w, tag);
            F_XRGB8888: push({8'hFF, w[23:0]}, tag);
            F_RGBA8888: push({w[7:0], w[31:24], w[23:16], w[15:8]}, tag);
            F_RGBX8888: push({8'hFF, w[31:24], w[23:16], w[15:8]}, tag);
            F_RGB888: begin
                for (int i = 0; i < 4; i++) bq.push_back(w[8*i +: 8]);
                while (bq.size() >= 3) begin
                    logic [7:0] b0, b1, b2;
                    b0 = bq.pop_front(); b1 = bq.pop_front(); b2 = bq.pop_front();
                    push({8'hFF, b2, b1, b0}, tag);
                end
            end
            F_IDX1, F_IDX2, F_IDX4, F_IDX8: begin
                int bpp;
                bpp = (f == F_IDX1) ? 1 : (f == F_IDX2) ? 2 : (f == F_IDX4) ? 4 : 8;
                for (int i = 0; i < 32 / bpp; i++) begin
                    logic [31:0] v;
                    v = (w >> (32 - bpp * (i + 1))) & ((32'd1 << bpp) - 1);
                    push({8'hFF, pal_model[v[7:0]]}, tag);
                end
            end
            default: ;
        endcase
        drive_word(f, w);
    endtask

    task automatic pal_write(input logic [7:0] a, input logic [23:0] d);
        @(negedge clk);
        pal_we = 1'b1; pal_addr = a; pal_wdata = d;
        @(negedge clk);
        pal_we = 1'b0;
        pal_model[a] = d;
    endtask

    task automatic pal_read_check(input logic [7:0] a, input logic [23:0] expv, input string tag);
        @(negedge clk);
        pal_re = 1'b1; pal_addr = a;
        @(negedge clk);
        pal_re = 1'b0;
        check(pal_rvalid && pal_rdata == expv, tag, {8'h00, pal_rdata}, {8'h00, expv});
    endtask

    task automatic drain();
        while (exp_q.size() != 0) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    // Monitor: pops and compares every produced pixel
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R11 unexpected pixel", out_pixel, 32'h0);
            end else begin
                logic [31:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(out_pixel == e, t, out_pixel, e);
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        nfail++;
        $display("FAIL R7 watchdog actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        // R12 reset state
        check(!out_valid && in_ready && !pal_rvalid, "R12 reset",
              {29'd0, out_valid, in_ready, pal_rvalid}, 32'h2);
        rst_n = 1'b1;
        @(negedge clk);
        check(!out_valid && in_ready && !pal_rvalid, "R12 after reset",
              {29'd0, out_valid, in_ready, pal_rvalid}, 32'h2);

        // Palette load and readback (R9)
        for (int i = 0; i < 16; i++) pal_write(8'(i), 24'h10_2030 * 24'(i + 1) ^ 24'hA5_5A00);
        pal_write(8'h5A, 24'h123456);
        pal_write(8'hC3, 24'hFEDCBA);
        pal_write(8'hFF, 24'h0F0F0F);
        pal_read_check(8'h5A, 24'h123456, "R9 readback");
        pal_read_check(8'h03, pal_model[3], "R9 readback low entry");

        // Direct colour formats
        send(F_ARGB4444, 32'h1234_F0A5, "R1 R2 ARGB4444");
        send(F_RGBA4444, 32'h9C3E_0F71, "R2 RGBA4444");
        send(F_XRGB4444, 32'h0ABC_7123, "R4 xRGB4444");
        send(F_RGB565,   32'hFFFF_0801, "R3 RGB565");
        send(F_RGB565,   32'h07E0_F81F, "R3 RGB565 mix");
        send(F_ARGB1555, 32'h8000_7FFF, "R3 ARGB1555");
        send(F_XRGB1555, 32'h0421_8C63, "R4 xRGB1555");
        send(F_ARGB8888, 32'h8011_2233, "R5 ARGB8888");
        send(F_RGBA8888, 32'h1122_3344, "R5 RGBA8888");
        send(F_XRGB8888, 32'h0055_6677, "R4 xRGB8888");
        send(F_RGBX8888, 32'hAABB_CC00, "R4 RGBx8888");

        // 24-bit packed across words (R6)
        send(F_RGB888, 32'h4433_2211, "R6 w0");
        send(F_RGB888, 32'h8877_6655, "R6 w1");
        send(F_RGB888, 32'hCCBB_AA99, "R6 w2");
        send(F_RGB888, 32'h0302_0100, "R6 w3");
        send(F_RGB888, 32'h0706_0504, "R6 w4");
        send(F_RGB888, 32'h0B0A_0908, "R6 w5");
        send(F_RGB888, 32'hDEAD_BEEF, "R6 realign a");
        send(F_ARGB8888, 32'h0102_0304, "R6 break");
        send(F_RGB888, 32'h7766_5544, "R6 realign b");
        drain();

        // Indexed formats (R8), with R7 ready and rate checks on the 1-bit word
        send(F_IDX1, 32'hA5F0_0F5A, "R8 idx1");
        @(negedge clk);
        check(!in_ready, "R7 ready low mid-word", {31'd0, in_ready}, 32'h0);
        while (!out_valid) @(negedge clk);
        begin
            int run;
            run = 0;
            for (int i = 0; i < 32; i++) begin
                if (out_valid) run++;
                @(negedge clk);
            end
            check(run == 32, "R7 one pixel per cycle", 32'(run), 32'd32);
        end
        send(F_IDX2, 32'h1B6C_E4D2, "R8 idx2");
        send(F_IDX4, 32'h0F1E_2D3C, "R8 idx4");
        send(F_IDX8, 32'h5AC3_FF05, "R8 idx8");
        drain();

        // Reserved code (R11)
        send(F_RSVD, 32'hFFFF_FFFF, "R11");
        begin
            int seen;
            seen = 0;
            for (int i = 0; i < 4; i++) begin
                @(negedge clk);
                if (out_valid) seen++;
            end
            check(seen == 0 && in_ready, "R11 no pixel from reserved", 32'(seen), 32'd0);
        end
        send(F_ARGB8888, 32'hCAFE_F00D, "R11 follow-up");
        drain();

        // Palette write on the same edge as a lookup of that entry (R10)
        begin
            logic [23:0] oldc, newc;
            oldc = pal_model[5];
            newc = 24'h77_8899;
            push({8'hFF, oldc}, "R10 first old");
            push({8'hFF, oldc}, "R10 same-edge old");
            push({8'hFF, newc}, "R10 later new");
            push({8'hFF, newc}, "R10 later new");
            drive_word(F_IDX8, 32'h0505_0505);
            @(negedge clk);
            @(negedge clk);
            pal_we = 1'b1; pal_addr = 8'h05; pal_wdata = newc;
            @(negedge clk);
            pal_we = 1'b0;
            pal_model[5] = newc;
            drain();
            pal_read_check(8'h05, newc, "R9 R10 write landed");
        end

        check(exp_q.size() == 0, "R7 scoreboard empty", 32'(exp_q.size()), 32'd0);
        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end

endmodule